// File: doc/BRIEF.md
# Interrupt Pending and Masking Unit

This block keeps an eight-level pending vector, one bit per interrupt level, and decides whether the core should take an interrupt. Sources raise a level through a post port and drop it through a clear port. Each port carries a level index. A single strobe wipes the whole vector. A built-in count/compare timer raises one pending level, which a 3-bit select input chooses, when the running count reaches a nonzero compare value.

The request line is gated by three status inputs: a global enable, an error-level flag and an exception-level flag. It is also gated by an 8-bit mask. It rises only when the mask and the pending vector are both nonzero. The request and the pending vector are registered and change on the same clock edge. A post or clear index outside the legal range is refused and reported on an error output.

Top module: `irq_pend_unit`

## Requirements
- R1: While reset is high at a clock edge, the pending vector, request, error flag, count and compare value all become zero.
- R2: A post with index code 0 to 7 sets that bit of `pendVec` at the next edge and leaves all other bits unchanged.
- R3: A clear with index code 0 to 7 clears that bit of `pendVec` at the next edge and leaves all other bits unchanged.
- R4: A post or clear with index code 8 to 15 leaves `pendVec` unchanged and drives `reqErr` high for the one cycle after it.
- R5: `clrAll` zeroes `pendVec` at the next edge. It overrides a post, a clear and a timer match in the same cycle.
- R6: When a post and a clear name the same bit in the same cycle, the bit ends up set.
- R7: The count increments once per cycle in which `tickEn` is high. When the count equals the compare value and is nonzero, bit `timerSel` of `pendVec` is set at the next edge.
- R8: A count of zero never produces a timer match, even when the compare value is also zero.
- R9: A compare write loads `cmpData` and clears bit `timerSel` at the next edge. A timer match in the same cycle does not set that bit.
- R10: `irqReq` is zero after any edge at which `globalEn` was 0, `errLevel` was 1 or `excLevel` was 1.
- R11: With the gate open, `irqReq` after an edge is 1 exactly when `intMask` was nonzero and the new `pendVec` is nonzero. It changes on the same edge as `pendVec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | Count increment enable |
| postValid | input | 1 | Post request strobe |
| postIdx | input | 4 | Level index of the post |
| clrValid | input | 1 | Clear request strobe |
| clrIdx | input | 4 | Level index of the clear |
| clrAll | input | 1 | Wipe the whole pending vector |
| cmpWrite | input | 1 | Compare register write strobe |
| cmpData | input | 16 | Compare write value |
| timerSel | input | 3 | Pending level driven by the timer |
| globalEn | input | 1 | Global interrupt enable |
| errLevel | input | 1 | Error-level flag, blocks requests when 1 |
| excLevel | input | 1 | Exception-level flag, blocks requests when 1 |
| intMask | input | 8 | Interrupt mask |
| irqReq | output | 1 | Registered interrupt request |
| pendVec | output | 8 | Current pending vector |
| reqErr | output | 1 | Illegal index seen in the previous cycle |

## Verification
Several functions can fall in the same cycle. The two that matter most are a post and a clear aimed at the same bit, and a timer match that coincides with a compare write. The bench drives each pair at once on one clock edge. It then judges the vector sampled after that edge against the stated precedence: the post wins, and the compare write suppresses the match. Clear-all is combined with a post in the same way, and that result is checked too.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LEVELS = 8;
  localparam int SEL_W  = $clog2(LEVELS);

  typedef struct packed {
    logic [LEVELS-1:0] setMask;
    logic [LEVELS-1:0] clrMask;
    logic              wipe;
    logic              badReq;
    logic              reqAllow;
  } strobe_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int IDX_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        postValid,
  input  logic [IDX_W-1:0]            postIdx,
  input  logic                        clrValid,
  input  logic [IDX_W-1:0]            clrIdx,
  input  logic                        clrAll,
  input  logic                        cmpWrite,
  input  logic                        timerHit,
  input  logic [irq_pkg::SEL_W-1:0]   timerSel,
  input  logic                        globalEn,
  input  logic                        errLevel,
  input  logic                        excLevel,
  input  logic [irq_pkg::LEVELS-1:0]  intMask,
  output irq_pkg::strobe_t            strobes
);
  import irq_pkg::*;

  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(LEVELS);

  logic postBad, clrBad, timerSet;

  assign postBad  = postValid && (postIdx >= LIMIT);
  assign clrBad   = clrValid && (clrIdx >= LIMIT);
  // a compare write retires the timer level, so a match in that cycle is dropped
  assign timerSet = timerHit && !cmpWrite;

  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    assign strobes.setMask[i] = (postValid && postIdx == IDX_W'(i)) ||
                                (timerSet && timerSel == SEL_W'(i));
    assign strobes.clrMask[i] = (clrValid && clrIdx == IDX_W'(i)) ||
                                (cmpWrite && timerSel == SEL_W'(i));
  end

  assign strobes.wipe     = clrAll;
  assign strobes.badReq   = postBad || clrBad;
  assign strobes.reqAllow = globalEn && !errLevel && !excLevel && (intMask != '0);

  // R4: an out-of-range index never turns into a set or clear strobe
  assert_bad_no_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    (postBad && !clrValid && !timerSet && !cmpWrite) |-> (strobes.setMask == '0));

  // R10: a closed gate never permits a request
  assert_gate_closed_R10: assert property (@(posedge clk) disable iff (rst)
    (!globalEn || errLevel || excLevel) |-> !strobes.reqAllow);
endmodule

// File: rtl/irq_dpath.sv
module irq_dpath #(
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tickEn,
  input  logic                        cmpWrite,
  input  logic [CNT_W-1:0]            cmpData,
  input  logic [irq_pkg::SEL_W-1:0]   timerSel,
  input  irq_pkg::strobe_t            strobes,
  output logic                        timerHit,
  output logic                        irqReq,
  output logic [irq_pkg::LEVELS-1:0]  pendVec,
  output logic                        reqErr
);
  import irq_pkg::*;

  logic [CNT_W-1:0]  countReg, compareReg;
  logic [LEVELS-1:0] pendNext;

  assign timerHit = (countReg == compareReg) && (countReg != '0);

  always_comb begin
    if (strobes.wipe) pendNext = '0;
    else              pendNext = (pendVec & ~strobes.clrMask) | strobes.setMask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendVec    <= '0;
      irqReq     <= 1'b0;
      reqErr     <= 1'b0;
      countReg   <= '0;
      compareReg <= '0;
    end else begin
      pendVec <= pendNext;
      irqReq  <= strobes.reqAllow && (pendNext != '0);
      reqErr  <= strobes.badReq;
      if (tickEn)   countReg   <= countReg + 1'b1;
      if (cmpWrite) compareReg <= cmpData;
    end
  end

  // R5: a wipe leaves nothing pending
  assert_wipe_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.wipe |=> (pendVec == '0));

  // R7: a timer match without wipe or compare write sets the selected level
  assert_timer_sets_R7: assert property (@(posedge clk) disable iff (rst)
    (timerHit && !strobes.wipe && !cmpWrite) |=> pendVec[$past(timerSel)]);

  // R11: a request is never raised with an empty pending vector
  assert_req_needs_pend_R11: assert property (@(posedge clk) disable iff (rst)
    irqReq |-> (pendVec != '0));

  // R8: a zero count never counts as a match
  assert_zero_count_R8: assert property (@(posedge clk) disable iff (rst)
    (countReg == '0) |-> !timerHit);

  // R4: an illegal index is reported one cycle later
  assert_err_flag_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.badReq |=> reqErr);
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
  parameter int CNT_W = 16,
  parameter int IDX_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tickEn,
  input  logic                        postValid,
  input  logic [IDX_W-1:0]            postIdx,
  input  logic                        clrValid,
  input  logic [IDX_W-1:0]            clrIdx,
  input  logic                        clrAll,
  input  logic                        cmpWrite,
  input  logic [CNT_W-1:0]            cmpData,
  input  logic [irq_pkg::SEL_W-1:0]   timerSel,
  input  logic                        globalEn,
  input  logic                        errLevel,
  input  logic                        excLevel,
  input  logic [irq_pkg::LEVELS-1:0]  intMask,
  output logic                        irqReq,
  output logic [irq_pkg::LEVELS-1:0]  pendVec,
  output logic                        reqErr
);
  irq_pkg::strobe_t strobes;
  logic timerHit;

  irq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .postValid(postValid), .postIdx(postIdx),
    .clrValid(clrValid), .clrIdx(clrIdx),
    .clrAll(clrAll), .cmpWrite(cmpWrite),
    .timerHit(timerHit), .timerSel(timerSel),
    .globalEn(globalEn), .errLevel(errLevel), .excLevel(excLevel),
    .intMask(intMask), .strobes(strobes)
  );

  irq_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rst(rst), .tickEn(tickEn),
    .cmpWrite(cmpWrite), .cmpData(cmpData), .timerSel(timerSel),
    .strobes(strobes), .timerHit(timerHit),
    .irqReq(irqReq), .pendVec(pendVec), .reqErr(reqErr)
  );
endmodule

// File: tb/sim_irq_pend_unit.sv
module sim_irq_pend_unit;
  logic clk = 1'b0;
  logic rst, tickEn, postValid, clrValid, clrAll, cmpWrite;
  logic globalEn, errLevel, excLevel;
  logic [3:0]  postIdx, clrIdx;
  logic [15:0] cmpData;
  logic [2:0]  timerSel;
  logic [7:0]  intMask, pendVec;
  logic irqReq, reqErr;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  irq_pend_unit u0 (
    .clk(clk), .rst(rst), .tickEn(tickEn),
    .postValid(postValid), .postIdx(postIdx),
    .clrValid(clrValid), .clrIdx(clrIdx), .clrAll(clrAll),
    .cmpWrite(cmpWrite), .cmpData(cmpData), .timerSel(timerSel),
    .globalEn(globalEn), .errLevel(errLevel), .excLevel(excLevel),
    .intMask(intMask), .irqReq(irqReq), .pendVec(pendVec), .reqErr(reqErr)
  );

  // {post, postIdx, clr, clrIdx, all, expected pending, expected error}
  localparam logic [19:0] VEC [8] = '{
    {1'b1, 4'd3,  1'b0, 4'd0,  1'b0, 8'h08, 1'b0},  // R2
    {1'b1, 4'd7,  1'b0, 4'd0,  1'b0, 8'h88, 1'b0},  // R2
    {1'b0, 4'd0,  1'b1, 4'd3,  1'b0, 8'h80, 1'b0},  // R3
    {1'b1, 4'd9,  1'b0, 4'd0,  1'b0, 8'h80, 1'b1},  // R4
    {1'b0, 4'd0,  1'b1, 4'd12, 1'b0, 8'h80, 1'b1},  // R4
    {1'b1, 4'd0,  1'b1, 4'd0,  1'b0, 8'h81, 1'b0},  // R6
    {1'b1, 4'd2,  1'b1, 4'd7,  1'b0, 8'h05, 1'b0},  // R2 R3
    {1'b1, 4'd4,  1'b0, 4'd0,  1'b1, 8'h00, 1'b0}   // R5
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    postValid = 0; clrValid = 0; clrAll = 0; cmpWrite = 0;
    postIdx = 0; clrIdx = 0; cmpData = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1; idle(); tickEn = 0;
    step(); step();
    @(negedge clk); rst = 0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(); tickEn = 0; timerSel = 0;
    globalEn = 1; errLevel = 0; excLevel = 0; intMask = 8'hff;
    rst = 1;
    step(); step();
    check("R1 pend", pendVec, 0);
    check("R1 irq", irqReq, 0);
    check("R1 err", reqErr, 0);
    @(negedge clk); rst = 0;

    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      {postValid, postIdx, clrValid, clrIdx, clrAll} = VEC[k][19:9];
      step();
      check($sformatf("R2-6 vec%0d pend", k), pendVec, VEC[k][8:1]);
      check($sformatf("R4 vec%0d err", k), reqErr, VEC[k][0]);
      check($sformatf("R11 vec%0d irq", k), irqReq, VEC[k][8:1] != 0);
      @(negedge clk); idle();
    end

    // R4 error lasts one cycle
    @(negedge clk); postValid = 1; postIdx = 4'd15; step();
    @(negedge clk); idle(); step();
    check("R4 err drop", reqErr, 0);

    // R10 gating
    @(negedge clk); postValid = 1; postIdx = 1; globalEn = 0; step();
    check("R10 enable off", irqReq, 0);
    check("R2 pend with gate", pendVec, 8'h02);
    @(negedge clk); idle(); globalEn = 1; errLevel = 1; step();
    check("R10 err level", irqReq, 0);
    @(negedge clk); errLevel = 0; excLevel = 1; step();
    check("R10 exc level", irqReq, 0);
    @(negedge clk); excLevel = 0; intMask = 0; step();
    check("R11 mask zero", irqReq, 0);
    @(negedge clk); intMask = 8'h01; step();
    check("R11 mask other bit", irqReq, 1);

    // R5 over timer later; R8 zero count with zero compare
    doReset();
    timerSel = 3'd2;
    step(); step(); step();
    check("R8 zero count", pendVec, 0);

    // R7 timer match on count 3
    @(negedge clk); cmpWrite = 1; cmpData = 16'd3; timerSel = 3'd4; tickEn = 1;
    step();                         // compare=3, count=1
    @(negedge clk); idle(); step(); // count=2
    step();                         // count=3
    check("R7 before match", pendVec, 0);
    @(negedge clk); tickEn = 0; step();
    check("R7 match sets", pendVec, 8'h10);
    check("R7 irq", irqReq, 1);

    // R9 compare write clears and suppresses a live match
    @(negedge clk); cmpWrite = 1; cmpData = 16'd3; step();
    check("R9 write clears", pendVec, 0);
    @(negedge clk); idle(); step();
    check("R7 match resumes", pendVec, 8'h10);

    // R5 wipe beats a live match
    @(negedge clk); clrAll = 1; step();
    check("R5 wipe over timer", pendVec, 0);
    @(negedge clk); cmpWrite = 1; cmpData = 16'd100; clrAll = 0; step();
    @(negedge clk); idle(); step();
    check("R9 no match after move", pendVec, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule